// File: doc/BRIEF.md
# Timer Capture, Compare and Pulse-Width Unit

This peripheral gives one 16-bit data register three uses, chosen by a 4-bit mode field. In capture modes it stores a free-running 16-bit timer value when an event occurs on a synchronised input pin or on a message-received strobe. Capture events can be every falling edge, every rising edge, or every 4th or 16th rising edge. In compare modes it checks the timer against the data register. On a match it can toggle, set or clear the output pin, raise an interrupt request, or send a one-cycle pulse that resets an external timer. In pulse-width mode it builds a 10-bit duty output against an external 10-bit time base. The upper eight duty bits come from the low data byte and the lower two come from the control byte.

Software reaches the block through a small byte-wide register port. Address 0 is the control byte. Addresses 1 and 2 are the low and high bytes of the data register. The interrupt output is a single-cycle request to an interrupt controller outside this block. The timers, the time base and the period strobe are also outside this block.

Top module: `tmr_cap_cmp_pwm`

## Requirements
- R1: After reset, pin_out, irq_set and evt_reset are 0, and the control byte and both data bytes read 0.
- R2: Address 0 reads {2'b00, control[5:0]}. Bits 7:6 always read 0. Address 1 is data[7:0], address 2 is data[15:8], and address 3 reads 0. Writes take effect at the clock edge.
- R3: pin_in goes through two flip-flops before edge detection. In mode 4'b0100 every falling edge captures, and in 4'b0101 every rising edge captures. The data register then holds the tmr_val presented two cycles after the pin change, and irq_set pulses in that same cycle.
- R4: Mode 4'b0110 captures on every 4th rising edge and 4'b0111 on every 16th. The edge counter clears on any write to the control byte.
- R5: Mode 4'b0011 captures tmr_val on the cycle msg_rx is high when MSG_CAP=1, and sets irq_set the next cycle. In every other mode msg_rx has no effect.
- R6: Mode 4'b0010: a compare match toggles pin_out and pulses irq_set.
- R7: Writing mode 4'b1000 drives pin_out low, and a match then drives it high. Writing mode 4'b1001 drives pin_out high, and a match then drives it low. In both modes a match pulses irq_set.
- R8: Mode 4'b1010: a match pulses irq_set and leaves pin_out unchanged.
- R9: Mode 4'b1011: a match pulses both irq_set and evt_reset. evt_reset is never high in any other mode.
- R10: A match is tmr_val equal to the data register. It acts once, in the cycle after equality begins. It acts again only after equality has ended and returned.
- R11: Modes 4'b11xx are pulse-width modes. On pwm_start the 10-bit duty {data[7:0], control[5:4]} is latched, and pin_out goes high unless the duty is 0. pin_out goes low on the cycle after pwm_cnt equals the latched duty. Data writes during a period do not affect that period.
- R12: In modes 4'b0000 and 4'b0001, no capture, interrupt or event occurs, and pin_out stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 data low, 2 data high) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| tmr_val | input | 16 | Free-running timer value |
| pwm_cnt | input | 10 | Pulse-width time-base count |
| pwm_start | input | 1 | Start of pulse-width period |
| pin_in | input | 1 | Asynchronous capture pin |
| msg_rx | input | 1 | Message-received strobe |
| pin_out | output | 1 | Output pin |
| irq_set | output | 1 | One-cycle interrupt request |
| evt_reset | output | 1 | One-cycle timer reset event |

## Verification
The capture path is driven with random pin toggles at random spacing in each of the four edge modes. This separates falling-edge from rising-edge capture and tests whether the prescale count survives a control rewrite. The compare path gets a random timer sequence, biased towards the match value and held on it for runs of cycles. This exposes repeated firing and wrong pin actions across the five compare modes. The pulse-width path is tried with duty values of 0, 513, 129, 1023 and random values, and with a data write in the middle of a period, which shows whether the duty is latched only at the period boundary. The off and reserved modes are probed with every stimulus at once.

// File: rtl/tmr_cap_cmp_pwm.sv
module tmr_cap_cmp_pwm #(
  parameter bit MSG_CAP = 1'b1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic [15:0] tmr_val,
  input  logic [9:0]  pwm_cnt,
  input  logic        pwm_start,
  input  logic        pin_in,
  input  logic        msg_rx,
  output logic        pin_out,
  output logic        irq_set,
  output logic        evt_reset
);
  localparam logic [3:0] M_TGL  = 4'b0010;
  localparam logic [3:0] M_MSG  = 4'b0011;
  localparam logic [3:0] M_FALL = 4'b0100;
  localparam logic [3:0] M_RISE = 4'b0101;
  localparam logic [3:0] M_R4   = 4'b0110;
  localparam logic [3:0] M_R16  = 4'b0111;
  localparam logic [3:0] M_SET  = 4'b1000;
  localparam logic [3:0] M_CLR  = 4'b1001;
  localparam logic [3:0] M_EVT  = 4'b1011;

  logic [5:0]  ctrl_q;
  logic [15:0] data_q;
  logic [1:0]  sync_q;
  logic        prev_q;
  logic [3:0]  pre_q;
  logic        match_q;
  logic [9:0]  duty_q;
  logic        pin_q, irq_q, evt_q;

  wire [3:0] mode    = ctrl_q[3:0];
  wire       ctrl_wr = wr_en && (addr == 2'd0);
  wire       is_pwm  = (mode[3:2] == 2'b11);
  wire       is_cmp  = (mode == M_TGL) || (mode[3:2] == 2'b10);
  wire       is_pre  = (mode == M_R4) || (mode == M_R16);
  wire       rise    = sync_q[1] & ~prev_q;
  wire       fall    = ~sync_q[1] & prev_q;
  wire       pre_end = (mode == M_R4) ? (pre_q[1:0] == 2'd3) : (pre_q == 4'd15);
  wire       match   = is_cmp && (tmr_val == data_q);
  wire       hit     = match && !match_q && !ctrl_wr;
  wire [9:0] duty_nx = {data_q[7:0], ctrl_q[5:4]};

  logic cap;
  always_comb begin
    case (mode)
      M_MSG:        cap = MSG_CAP && msg_rx;
      M_FALL:       cap = fall;
      M_RISE:       cap = rise;
      M_R4, M_R16:  cap = rise && pre_end;
      default:      cap = 1'b0;
    endcase
    if (ctrl_wr) cap = 1'b0;
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {2'b00, ctrl_q};
      2'd1:    rd_data = data_q[7:0];
      2'd2:    rd_data = data_q[15:8];
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_in};
      prev_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data[5:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (cap) data_q <= tmr_val;
    else if (wr_en && addr == 2'd1) data_q[7:0] <= wr_data;
    else if (wr_en && addr == 2'd2) data_q[15:8] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (ctrl_wr || !is_pre) pre_q <= '0;
    else if (rise) pre_q <= pre_end ? 4'd0 : pre_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      match_q <= match && !ctrl_wr;
      irq_q   <= cap || hit;
      evt_q   <= hit && (mode == M_EVT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else if (ctrl_wr) duty_q <= '0;
    else if (is_pwm && pwm_start) duty_q <= duty_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (ctrl_wr) pin_q <= (wr_data[3:0] == M_CLR);
    else if (is_pwm) begin
      if (pwm_start) pin_q <= (duty_nx != 10'd0);
      else if (pwm_cnt == duty_q) pin_q <= 1'b0;
    end else if (hit) begin
      case (mode)
        M_TGL:   pin_q <= ~pin_q;
        M_SET:   pin_q <= 1'b1;
        M_CLR:   pin_q <= 1'b0;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin_out   = pin_q;
  assign irq_set   = irq_q;
  assign evt_reset = evt_q;
endmodule

// File: rtl/tmr_cap_cmp_pwm_chk.sv
module tmr_cap_cmp_pwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [3:0] mode,
  input logic [9:0] duty_next,
  input logic       pwm_start,
  input logic       pin_out,
  input logic       irq_set,
  input logic       evt_reset
);
  wire ctrl_wr = wr_en && (addr == 2'd0);

  p_evt_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reset |-> $past(mode) == 4'b1011);

  p_flag_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b1010 && !ctrl_wr) |=> $stable(pin_out));

  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b0010 && !ctrl_wr) |=> (irq_set ? (pin_out != $past(pin_out)) : $stable(pin_out)));

  p_zero_duty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b11 && pwm_start && duty_next == 10'd0 && !ctrl_wr) |=> !pin_out);

  p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 4'b0000 || mode == 4'b0001) && !ctrl_wr) |=> (!irq_set && !evt_reset && !pin_out));
endmodule

bind tmr_cap_cmp_pwm tmr_cap_cmp_pwm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .mode(ctrl_q[3:0]), .duty_next({data_q[7:0], ctrl_q[5:4]}),
  .pwm_start(pwm_start), .pin_out(pin_out), .irq_set(irq_set), .evt_reset(evt_reset)
);

// File: tb/test_tmr_cap_cmp_pwm.sv
`timescale 1ns/1ps
module test_tmr_cap_cmp_pwm;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] tmr_val = 16'h1000;
  logic [9:0]  pwm_cnt = 10'd0;
  logic        pwm_start = 1'b0, pin_in = 1'b0, msg_rx = 1'b0;
  logic        pin_out, irq_set, evt_reset;

  int  n_run = 0, n_fail = 0;
  bit  auto_t = 1'b1;
  int  exp_pre = 0;
  logic [15:0] exp_data = 16'h0;

  always #10 clk = ~clk;

  tmr_cap_cmp_pwm #(.MSG_CAP(1'b1)) i_tmr_cap_cmp_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tmr_val(tmr_val), .pwm_cnt(pwm_cnt), .pwm_start(pwm_start),
    .pin_in(pin_in), .msg_rx(msg_rx), .pin_out(pin_out), .irq_set(irq_set),
    .evt_reset(evt_reset));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (auto_t) tmr_val = tmr_val + 16'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data; addr = 2'd0; #1;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] l, h;
    rd(2'd1, l); rd(2'd2, h);
    v = {h, l};
  endtask

  function automatic bit cap_pred(input logic [3:0] m, input bit rising);
    bit q = 1'b0;
    case (m)
      4'b0100: q = !rising;
      4'b0101: q = rising;
      4'b0110, 4'b0111: if (rising) begin
        if (exp_pre == ((m == 4'b0110) ? 3 : 15)) begin q = 1'b1; exp_pre = 0; end
        else exp_pre++;
      end
      default: q = 1'b0;
    endcase
    return q;
  endfunction

  task automatic edge_cap(input logic [3:0] m, input string tag);
    logic [15:0] t, v;
    bit q;
    t = tmr_val;
    pin_in = ~pin_in;
    q = cap_pred(m, pin_in);
    cyc(); cyc(); cyc();
    chk({tag, " irq"}, irq_set, q);
    if (q) exp_data = t + 16'd2;
    rd16(v);
    chk({tag, " data"}, v, exp_data);
  endtask

  function automatic logic [9:0] duty_of(input logic [7:0] lo, input logic [1:0] dc);
    return {lo, dc};
  endfunction

  task automatic pwm_period(input int exp, input bit midwr, input logic [7:0] nlo, input string tag);
    int bad = 0;
    for (int i = 0; i < 1024; i++) begin
      pwm_cnt = 10'(i);
      pwm_start = (i == 0);
      if (midwr && i == 300) begin wr_en = 1'b1; addr = 2'd1; wr_data = nlo; end
      else begin wr_en = 1'b0; addr = 2'd0; end
      cyc();
      if (pin_out !== (i < exp)) bad++;
    end
    pwm_start = 1'b0; wr_en = 1'b0; addr = 2'd0;
    chk(tag, bad, 0);
  endtask

  task automatic cmp_run(input logic [3:0] m, input logic [15:0] d, input int n, input string tag);
    bit mq = 1'b0, p, hitv;
    auto_t = 1'b0;
    tmr_val = d + 16'd1;
    wr(2'd1, d[7:0]); wr(2'd2, d[15:8]);
    wr(2'd0, {4'b0000, m});
    p = (m == 4'b1001);
    chk({tag, " entry pin"}, pin_out, p);
    for (int k = 0; k < n; k++) begin
      tmr_val = ($urandom_range(0, 2) == 0) ? d : 16'($urandom);
      if (k % 17 < 3) tmr_val = d;
      hitv = (tmr_val == d) && !mq;
      mq = (tmr_val == d);
      if (hitv) begin
        if (m == 4'b0010) p = ~p;
        else if (m == 4'b1000) p = 1'b1;
        else if (m == 4'b1001) p = 1'b0;
      end
      cyc();
      chk({tag, " pin/irq/evt"}, {pin_out, irq_set, evt_reset},
          {p, hitv, hitv && (m == 4'b1011)});
    end
    auto_t = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, t;
    void'($urandom(32'd1234));
    #3;
    chk("R1 reset outputs", {pin_out, irq_set, evt_reset}, 3'b000);
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    rd(2'd0, b); chk("R1 ctrl after reset", b, 8'h00);
    rd16(v);     chk("R1 data after reset", v, 16'h0000);

    wr(2'd0, 8'hF1);
    rd(2'd0, b); chk("R2 ctrl readback upper bits zero", b, 8'h31);
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd16(v);     chk("R2 data readback", v, 16'h3CA5);
    rd(2'd3, b); chk("R2 unused address", b, 8'h00);

    // R12: reserved mode 0001 then off mode 0000, with every stimulus active
    for (int r = 0; r < 2; r++) begin
      int bad = 0;
      wr(2'd0, (r == 0) ? 8'h01 : 8'h00);
      auto_t = 1'b0; tmr_val = 16'h3CA5;
      for (int k = 0; k < 20; k++) begin
        pin_in = ~pin_in; msg_rx = k[0];
        cyc();
        if (irq_set || evt_reset || pin_out) bad++;
      end
      msg_rx = 1'b0; auto_t = 1'b1;
      chk("R12 off/reserved outputs quiet", bad, 0);
      rd16(v); chk("R12 off/reserved no capture", v, 16'h3CA5);
    end
    exp_data = 16'h3CA5;
    pin_in = 1'b0; cyc(); cyc(); cyc(); cyc();

    // R3/R4 random edges in each edge mode
    for (int mi = 4; mi < 8; mi++) begin
      wr(2'd0, 8'(mi)); exp_pre = 0;
      for (int k = 0; k < 40; k++) begin
        edge_cap(4'(mi), (mi < 6) ? "R3 edge capture" : "R4 prescaled capture");
        for (int g = $urandom_range(0, 3); g > 0; g--) cyc();
      end
    end
    // R4: counter clears on control rewrite
    wr(2'd0, 8'h06); exp_pre = 0;
    if (pin_in) edge_cap(4'h6, "R4 align");
    edge_cap(4'h6, "R4 pre rise1"); edge_cap(4'h6, "R4 pre fall1");
    edge_cap(4'h6, "R4 pre rise2"); edge_cap(4'h6, "R4 pre fall2");
    wr(2'd0, 8'h06); exp_pre = 0;
    for (int k = 0; k < 8; k++) edge_cap(4'h6, "R4 count after rewrite");

    // R5: message capture, and ignored in an edge mode
    wr(2'd0, 8'h03);
    t = tmr_val; msg_rx = 1'b1; cyc(); msg_rx = 1'b0;
    chk("R5 msg irq", irq_set, 1'b1);
    rd16(v); chk("R5 msg data", v, t);
    exp_data = t;
    wr(2'd0, 8'h05);
    msg_rx = 1'b1; cyc(); msg_rx = 1'b0; cyc();
    chk("R5 msg ignored irq", irq_set, 1'b0);
    rd16(v); chk("R5 msg ignored data", v, exp_data);

    // R6-R9: compare modes with random timer
    cmp_run(4'b0010, 16'h4321, 60, "R6 toggle");
    cmp_run(4'b1000, 16'h0007, 60, "R7 set high");
    cmp_run(4'b1001, 16'hFFFF, 60, "R7 set low");
    cmp_run(4'b1010, 16'h8000, 60, "R8 flag only");
    cmp_run(4'b1011, 16'h1234, 60, "R9 event");
    // R10 directed: held equality fires once
    auto_t = 1'b0;
    wr(2'd1, 8'h55); wr(2'd2, 8'h00); tmr_val = 16'h0000;
    wr(2'd0, 8'h0A);
    tmr_val = 16'h0055; cyc();
    chk("R10 first match irq", irq_set, 1'b1);
    cyc(); chk("R10 held match no irq", irq_set, 1'b0);
    cyc(); chk("R10 held match no irq 2", irq_set, 1'b0);
    tmr_val = 16'h0056; cyc(); tmr_val = 16'h0055; cyc();
    chk("R10 re-entered match irq", irq_set, 1'b1);
    auto_t = 1'b1;

    // R11: pulse-width
    wr(2'd1, 8'h80); wr(2'd0, 8'h1C);
    chk("R11 low before first period", pin_out, 1'b0);
    pwm_period(int'(duty_of(8'h80, 2'd1)), 1'b1, 8'h20, "R11 duty 513 with mid write");
    pwm_period(int'(duty_of(8'h20, 2'd1)), 1'b0, 8'h00, "R11 duty 129 next period");
    wr(2'd1, 8'hFF); wr(2'd0, 8'h3F);
    pwm_period(1023, 1'b0, 8'h00, "R11 duty 1023");
    wr(2'd1, 8'h00); wr(2'd0, 8'h0C);
    pwm_period(0, 1'b0, 8'h00, "R11 duty zero");
    for (int k = 0; k < 3; k++) begin
      logic [7:0] lo; logic [1:0] dc;
      lo = 8'($urandom); dc = 2'($urandom);
      wr(2'd1, lo); wr(2'd0, {2'b00, dc, 4'b1101});
      pwm_period(int'(duty_of(lo, dc)), 1'b0, 8'h00, "R11 random duty");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule